// File: doc/BRIEF.md
# Coprocessor Mailbox Register File

This block is the shared register window through which a host CPU hands commands to a power-management coprocessor and collects the results. The host side is a plain 32-bit register bus that reaches a command word, a status word, four argument words and a set of read-only telemetry words: two supply voltages, a temperature, the operating frequency, the active performance state, a firmware revision, a heartbeat count and a firmware signature word. When valid firmware is present, the signature word reads 0xA11600D1.

The host only issues a command while the command word reads zero. It clears the status word, loads the arguments, writes the command code, and then rings a separate doorbell so that the coprocessor wakes up. The coprocessor has its own port. Through it, the coprocessor reads the window, posts status, results and telemetry, and fetches arguments by index. It ends a command with a one-cycle done strobe. That strobe returns the command word to zero and sends a one-cycle completion interrupt back to the host. The coprocessor firmware itself is outside this block, and a stub in the bench plays its part.

Top module: `mbox_regfile`

## Requirements
- R1: While reset is asserted and directly after it, every mailbox word reads zero (the signature word included), and `hostIrq`, `cpIrq` and `cmdBusy` are low.
- R2: The host writes and reads back the command word at offset 0x00, the status word at 0x04 and the argument words 0 to 3 at 0x18, 0x1C, 0x20 and 0x24.
- R3: Host writes to the telemetry offsets are ignored. These offsets are voltage0 0x08, temp0 0x0C, revision 0x28, performance state 0x2C, heartbeat 0x30, signature 0x34, voltage1 0x40 and frequency 0x50. Any offset that is not mapped reads as zero.
- R4: The coprocessor port writes the status, argument and telemetry words at the same offsets, and the host reads the written values. For example, a signature of 0xA11600D1 is readable at 0x34.
- R5: A coprocessor write to the command offset has no effect. `cpRdData` returns the word at `cpAddr`.
- R6: `cmdBusy` is high exactly while the command word is nonzero.
- R7: If `cpDone` is sampled high at a clock edge, the command word reads zero after that edge, and `hostIrq` is high for exactly the following cycle.
- R8: If a host command write and `cpDone` fall on the same edge, the host's value is kept and `hostIrq` still pulses.
- R9: If the host and the coprocessor write the same status or argument word on the same edge, the coprocessor's value is kept. Example status codes are success 0xF0, no map 0xF3 and failure 0xFF.
- R10: A doorbell write at doorbell offset 0x4 with data bit 31 set raises `cpIrq` from the next cycle on. A write to another offset, or a write with bit 31 clear, has no effect. `cpIrq` stays high until `cpDbAck`, and a set on the same edge as an acknowledge wins.
- R11: `cpParamData` returns argument word `cpParamIdx` for indices 0 to 3. Any index of 4 or more returns argument word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host byte offset for both read and write |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data for `hostAddr`, combinational |
| cmdBusy | output | 1 | Command word is nonzero |
| hostIrq | output | 1 | One-cycle command completion interrupt to the host |
| dbWrEn | input | 1 | Doorbell block write strobe |
| dbAddr | input | 4 | Doorbell block byte offset |
| dbWrMsb | input | 1 | Bit 31 of the doorbell write word |
| cpIrq | output | 1 | Pending doorbell interrupt to the coprocessor |
| cpDbAck | input | 1 | Coprocessor clears the pending doorbell |
| cpWrEn | input | 1 | Coprocessor write strobe |
| cpAddr | input | 8 | Coprocessor byte offset |
| cpWrData | input | 32 | Coprocessor write data |
| cpRdData | output | 32 | Coprocessor read data for `cpAddr`, combinational |
| cpParamIdx | input | 3 | Argument index for the indexed read |
| cpParamData | output | 32 | Argument word selected by `cpParamIdx`, aliased to word 0 when out of range |
| cpDone | input | 1 | Coprocessor finished the current command |

## Verification
The command word has two writers that can act on the same edge: a host command write and the coprocessor's done strobe. The bench drives both on one edge and expects the new host command to survive, `cmdBusy` to stay high and the completion pulse to appear anyway. The status word has the same kind of collision: the host clears it while the coprocessor posts a result in the same cycle, and the posted code must remain. The doorbell is tested the same way, with a ring and an acknowledge on one edge, and the interrupt must stay raised.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int DB_ADDR_W  = 4;
  localparam int NUM_PARAMS = 4;
  localparam int NUM_TEL    = 8;
  localparam int IDX_W      = 3;
  localparam int RID_W      = 4;
  localparam int PAR_IW     = $clog2(NUM_PARAMS);
  localparam int TEL_IW     = $clog2(NUM_TEL);

  // Byte offsets of the mailbox window
  localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_VOLT0 = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TEMP0 = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PAR0  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_REV   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_PST   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_HB    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SIG   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_VOLT1 = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_FREQ  = 8'h50;

  // Doorbell set register inside the interrupt block
  localparam logic [DB_ADDR_W-1:0] DB_SET_OFS = 4'h4;

  // Register identifiers; argument and telemetry entries are contiguous
  typedef enum logic [RID_W-1:0] {
    RID_NONE, RID_CMD, RID_STAT,
    RID_PAR0, RID_PAR1, RID_PAR2, RID_PAR3,
    RID_VOLT0, RID_TEMP0, RID_VOLT1, RID_FREQ,
    RID_PST, RID_REV, RID_HB, RID_SIG
  } regId_t;

  typedef struct packed {
    logic                  hostCmdWr;
    logic                  hostStatWr;
    logic [NUM_PARAMS-1:0] hostParWr;
    logic                  cpStatWr;
    logic [NUM_PARAMS-1:0] cpParWr;
    logic [NUM_TEL-1:0]    cpTelWr;
    logic                  dbSet;
    logic                  dbClr;
    logic                  cmdClr;
    logic                  doneEvt;
  } strobe_t;

  function automatic regId_t decodeAddr(input logic [ADDR_W-1:0] a);
    regId_t r;
    r = RID_NONE;
    if (a == OFS_CMD)   r = RID_CMD;
    if (a == OFS_STAT)  r = RID_STAT;
    for (int p = 0; p < NUM_PARAMS; p++)
      if (a == ADDR_W'(int'(OFS_PAR0) + 4 * p)) r = regId_t'(RID_W'(int'(RID_PAR0) + p));
    if (a == OFS_VOLT0) r = RID_VOLT0;
    if (a == OFS_TEMP0) r = RID_TEMP0;
    if (a == OFS_VOLT1) r = RID_VOLT1;
    if (a == OFS_FREQ)  r = RID_FREQ;
    if (a == OFS_PST)   r = RID_PST;
    if (a == OFS_REV)   r = RID_REV;
    if (a == OFS_HB)    r = RID_HB;
    if (a == OFS_SIG)   r = RID_SIG;
    return r;
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic                 hostWrEn,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic                 cpWrEn,
  input  logic [ADDR_W-1:0]    cpAddr,
  input  logic                 dbWrEn,
  input  logic [DB_ADDR_W-1:0] dbAddr,
  input  logic                 dbWrMsb,
  input  logic                 cpDbAck,
  input  logic                 cpDone,
  output regId_t               hostRid,
  output regId_t               cpRid,
  output strobe_t              stb
);
  always_comb begin
    hostRid = decodeAddr(hostAddr);
    cpRid   = decodeAddr(cpAddr);
    stb     = '0;

    // Command word: host only; host write beats the done clear
    stb.hostCmdWr = hostWrEn && (hostRid == RID_CMD);
    stb.doneEvt   = cpDone;
    stb.cmdClr    = cpDone && !stb.hostCmdWr;

    // Status word: coprocessor post beats host write
    stb.cpStatWr   = cpWrEn && (cpRid == RID_STAT);
    stb.hostStatWr = hostWrEn && (hostRid == RID_STAT) && !stb.cpStatWr;

    for (int p = 0; p < NUM_PARAMS; p++) begin
      stb.cpParWr[p]   = cpWrEn && (cpRid == regId_t'(RID_W'(int'(RID_PAR0) + p)));
      stb.hostParWr[p] = hostWrEn && (hostRid == regId_t'(RID_W'(int'(RID_PAR0) + p)))
                         && !stb.cpParWr[p];
    end

    // Telemetry: coprocessor only
    for (int t = 0; t < NUM_TEL; t++)
      stb.cpTelWr[t] = cpWrEn && (cpRid == regId_t'(RID_W'(int'(RID_VOLT0) + t)));

    // Doorbell: set-only by bit 31, set beats acknowledge
    stb.dbSet = dbWrEn && (dbAddr == DB_SET_OFS) && dbWrMsb;
    stb.dbClr = cpDbAck && !stb.dbSet;
  end
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  regId_t            hostRid,
  input  regId_t            cpRid,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] cpWrData,
  input  logic [IDX_W-1:0]  cpParamIdx,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] cpRdData,
  output logic [DATA_W-1:0] cpParamData,
  output logic              cmdBusy,
  output logic              hostIrq,
  output logic              cpIrq
);
  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] statReg;
  logic [DATA_W-1:0] parReg [NUM_PARAMS];
  logic [DATA_W-1:0] telReg [NUM_TEL];
  logic              dbPend;
  logic              doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      statReg <= '0;
      dbPend  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      if (stb.hostCmdWr)   cmdReg <= hostWrData;
      else if (stb.cmdClr) cmdReg <= '0;

      if (stb.cpStatWr)        statReg <= cpWrData;
      else if (stb.hostStatWr) statReg <= hostWrData;

      if (stb.dbSet)      dbPend <= 1'b1;
      else if (stb.dbClr) dbPend <= 1'b0;

      doneQ <= stb.doneEvt;
    end
  end

  for (genvar p = 0; p < NUM_PARAMS; p++) begin : g_par
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 parReg[p] <= '0;
      else if (stb.cpParWr[p])   parReg[p] <= cpWrData;
      else if (stb.hostParWr[p]) parReg[p] <= hostWrData;
    end
  end

  for (genvar t = 0; t < NUM_TEL; t++) begin : g_tel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               telReg[t] <= '0;
      else if (stb.cpTelWr[t]) telReg[t] <= cpWrData;
    end
  end

  // Two identical read ports: host and coprocessor
  regId_t            rdRid [2];
  logic [DATA_W-1:0] rdVal [2];
  assign rdRid[0] = hostRid;
  assign rdRid[1] = cpRid;

  for (genvar k = 0; k < 2; k++) begin : g_rd
    logic [PAR_IW-1:0] pOff;
    logic [TEL_IW-1:0] tOff;
    assign pOff = PAR_IW'(rdRid[k] - RID_PAR0);
    assign tOff = TEL_IW'(rdRid[k] - RID_VOLT0);
    always_comb begin
      rdVal[k] = '0;
      if (rdRid[k] == RID_CMD)
        rdVal[k] = cmdReg;
      else if (rdRid[k] == RID_STAT)
        rdVal[k] = statReg;
      else if (rdRid[k] >= RID_PAR0 && rdRid[k] <= RID_PAR3)
        rdVal[k] = parReg[pOff];
      else if (rdRid[k] >= RID_VOLT0)
        rdVal[k] = telReg[tOff];
    end
  end

  assign hostRdData  = rdVal[0];
  assign cpRdData    = rdVal[1];
  assign cpParamData = (cpParamIdx < IDX_W'(NUM_PARAMS)) ? parReg[cpParamIdx[PAR_IW-1:0]]
                                                         : parReg[0];
  assign cmdBusy = |cmdReg;
  assign hostIrq = doneQ;
  assign cpIrq   = dbPend;
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWrEn,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWrData,
  output logic [DATA_W-1:0]    hostRdData,
  output logic                 cmdBusy,
  output logic                 hostIrq,
  input  logic                 dbWrEn,
  input  logic [DB_ADDR_W-1:0] dbAddr,
  input  logic                 dbWrMsb,
  output logic                 cpIrq,
  input  logic                 cpDbAck,
  input  logic                 cpWrEn,
  input  logic [ADDR_W-1:0]    cpAddr,
  input  logic [DATA_W-1:0]    cpWrData,
  output logic [DATA_W-1:0]    cpRdData,
  input  logic [IDX_W-1:0]     cpParamIdx,
  output logic [DATA_W-1:0]    cpParamData,
  input  logic                 cpDone
);
  strobe_t stb;
  regId_t  hostRid;
  regId_t  cpRid;

  mbox_ctrl ctrl_i (
    .hostWrEn (hostWrEn),
    .hostAddr (hostAddr),
    .cpWrEn   (cpWrEn),
    .cpAddr   (cpAddr),
    .dbWrEn   (dbWrEn),
    .dbAddr   (dbAddr),
    .dbWrMsb  (dbWrMsb),
    .cpDbAck  (cpDbAck),
    .cpDone   (cpDone),
    .hostRid  (hostRid),
    .cpRid    (cpRid),
    .stb      (stb)
  );

  mbox_dpath dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .hostRid     (hostRid),
    .cpRid       (cpRid),
    .hostWrData  (hostWrData),
    .cpWrData    (cpWrData),
    .cpParamIdx  (cpParamIdx),
    .hostRdData  (hostRdData),
    .cpRdData    (cpRdData),
    .cpParamData (cpParamData),
    .cmdBusy     (cmdBusy),
    .hostIrq     (hostIrq),
    .cpIrq       (cpIrq)
  );
endmodule

// File: rtl/mbox_regfile_chk.sv
module mbox_regfile_chk
  import mbox_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostWrEn,
  input logic [ADDR_W-1:0]    hostAddr,
  input logic [DATA_W-1:0]    hostWrData,
  input logic [DATA_W-1:0]    hostRdData,
  input logic                 cmdBusy,
  input logic                 hostIrq,
  input logic                 dbWrEn,
  input logic [DB_ADDR_W-1:0] dbAddr,
  input logic                 dbWrMsb,
  input logic                 cpIrq,
  input logic                 cpDbAck,
  input logic                 cpDone
);
  logic ringSet;
  logic hostCmd;
  assign ringSet = dbWrEn && (dbAddr == DB_SET_OFS) && dbWrMsb;
  assign hostCmd = hostWrEn && (hostAddr == OFS_CMD);

  always @(posedge clk)
    if (!rstN) a_r1_reset_quiet: assert (!hostIrq && !cpIrq && !cmdBusy);

  a_r6_busy_matches: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == OFS_CMD) |-> (cmdBusy == (hostRdData != '0)));

  a_r7_irq_after_done: assert property (@(posedge clk) disable iff (!rstN)
    cpDone |=> hostIrq);

  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(cpDone));

  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cpDone && !hostCmd) |=> !cmdBusy);

  a_r8_host_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hostCmd && hostWrData != '0) |=> cmdBusy);

  a_r10_ring_sets: assert property (@(posedge clk) disable iff (!rstN)
    ringSet |=> cpIrq);

  a_r10_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cpIrq && !cpDbAck) |=> cpIrq);

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cpDbAck && !ringSet) |=> !cpIrq);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!cpIrq && !ringSet) |=> !cpIrq);
endmodule

bind mbox_regfile mbox_regfile_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .cmdBusy    (cmdBusy),
  .hostIrq    (hostIrq),
  .dbWrEn     (dbWrEn),
  .dbAddr     (dbAddr),
  .dbWrMsb    (dbWrMsb),
  .cpIrq      (cpIrq),
  .cpDbAck    (cpDbAck),
  .cpDone     (cpDone)
);

// File: tb/mbox_regfile_tb.sv
module mbox_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        cmdBusy;
  logic        hostIrq;
  logic        dbWrEn = 1'b0;
  logic [3:0]  dbAddr = '0;
  logic        dbWrMsb = 1'b0;
  logic        cpIrq;
  logic        cpDbAck = 1'b0;
  logic        cpWrEn = 1'b0;
  logic [7:0]  cpAddr = '0;
  logic [31:0] cpWrData = '0;
  logic [31:0] cpRdData;
  logic [2:0]  cpParamIdx = '0;
  logic [31:0] cpParamData;
  logic        cpDone = 1'b0;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mbox_regfile dut_i (.*);

  typedef struct packed {
    logic [7:0]  ofs;
    logic [31:0] wr;
    logic [31:0] exp;
  } vec_t;

  // Host write then read-back; telemetry and unmapped offsets expect zero
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 32'h0000_0041, 32'h0000_0041},
    '{8'h04, 32'h0000_00F0, 32'h0000_00F0},
    '{8'h18, 32'h1111_1111, 32'h1111_1111},
    '{8'h1C, 32'h2222_2222, 32'h2222_2222},
    '{8'h20, 32'h3333_3333, 32'h3333_3333},
    '{8'h24, 32'h4444_4444, 32'h4444_4444},
    '{8'h08, 32'hDEAD_BEEF, 32'h0000_0000},
    '{8'h34, 32'h0000_1234, 32'h0000_0000},
    '{8'h50, 32'h0000_0005, 32'h0000_0000},
    '{8'h3C, 32'h0000_0007, 32'h0000_0000},
    '{8'h14, 32'h0000_0009, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic cpWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cpWrEn = 1'b1; cpAddr = a; cpWrData = d;
    @(negedge clk);
    cpWrEn = 1'b0;
  endtask

  task automatic hostRd(input logic [7:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic ring(input logic [3:0] a, input logic msb);
    @(negedge clk);
    dbWrEn = 1'b1; dbAddr = a; dbWrMsb = msb;
    @(negedge clk);
    dbWrEn = 1'b0; dbWrMsb = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    hostRd(8'h00, rd); check("R1 cmd", rd, 32'h0);
    hostRd(8'h34, rd); check("R1 signature", rd, 32'h0);
    check("R1 irqs/busy", {29'h0, hostIrq, cpIrq, cmdBusy}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {29'h0, hostIrq, cpIrq, cmdBusy}, 32'h0);

    // R2 / R3 table
    for (int i = 0; i < NVEC; i++) begin
      hostWr(VECS[i].ofs, VECS[i].wr);
      hostRd(VECS[i].ofs, rd);
      check((VECS[i].exp != 0 || VECS[i].wr == 0) ? "R2 readback" : "R3 ignored/unmapped",
            rd, VECS[i].exp);
    end

    // R6 busy with nonzero command
    check("R6 busy", {31'h0, cmdBusy}, 32'h1);

    // R5 coprocessor cannot write command; cpRdData mirrors window
    cpWr(8'h00, 32'h0000_0099);
    hostRd(8'h00, rd); check("R5 cmd kept", rd, 32'h41);
    cpAddr = 8'h00; #1; check("R5 cpRdData", cpRdData, 32'h41);

    // R4 coprocessor writes
    cpWr(8'h34, 32'hA116_00D1);
    cpWr(8'h50, 32'h0000_03E8);
    cpWr(8'h1C, 32'h0000_0022);
    hostRd(8'h34, rd); check("R4 signature", rd, 32'hA116_00D1);
    hostRd(8'h50, rd); check("R4 frequency", rd, 32'h0000_03E8);
    hostRd(8'h1C, rd); check("R4 param1", rd, 32'h0000_0022);
    // R3 host write to signature after coprocessor set it
    hostWr(8'h34, 32'h0);
    hostRd(8'h34, rd); check("R3 signature unchanged", rd, 32'hA116_00D1);

    // R11 indexed argument read and aliasing
    cpParamIdx = 3'd1; #1; check("R11 idx1", cpParamData, 32'h0000_0022);
    cpParamIdx = 3'd3; #1; check("R11 idx3", cpParamData, 32'h4444_4444);
    cpParamIdx = 3'd4; #1; check("R11 idx4 alias", cpParamData, 32'h1111_1111);
    cpParamIdx = 3'd7; #1; check("R11 idx7 alias", cpParamData, 32'h1111_1111);

    // R7 done clears command, one-cycle host interrupt
    @(negedge clk); cpDone = 1'b1;
    @(negedge clk); cpDone = 1'b0;
    check("R7 irq high", {31'h0, hostIrq}, 32'h1);
    check("R6 idle", {31'h0, cmdBusy}, 32'h0);
    hostRd(8'h00, rd); check("R7 cmd cleared", rd, 32'h0);
    @(negedge clk);
    check("R7 irq one cycle", {31'h0, hostIrq}, 32'h0);

    // R8 host command write and done on the same edge
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 8'h00; hostWrData = 32'h30; cpDone = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; cpDone = 1'b0;
    hostRd(8'h00, rd); check("R8 host value kept", rd, 32'h30);
    check("R8 irq pulse", {31'h0, hostIrq}, 32'h1);
    check("R8 busy", {31'h0, cmdBusy}, 32'h1);

    // R9 status collision, coprocessor wins (0xF3 = no map)
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 8'h04; hostWrData = 32'h0;
    cpWrEn = 1'b1; cpAddr = 8'h04; cpWrData = 32'hF3;
    @(negedge clk);
    hostWrEn = 1'b0; cpWrEn = 1'b0;
    hostRd(8'h04, rd); check("R9 status collision", rd, 32'hF3);
    // R9 argument collision
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 8'h20; hostWrData = 32'h5;
    cpWrEn = 1'b1; cpAddr = 8'h20; cpWrData = 32'hFF;
    @(negedge clk);
    hostWrEn = 1'b0; cpWrEn = 1'b0;
    hostRd(8'h20, rd); check("R9 param collision", rd, 32'hFF);

    // R10 doorbell
    ring(4'h4, 1'b0); check("R10 bit31 clear", {31'h0, cpIrq}, 32'h0);
    ring(4'h0, 1'b1); check("R10 wrong offset", {31'h0, cpIrq}, 32'h0);
    ring(4'h4, 1'b1); check("R10 set", {31'h0, cpIrq}, 32'h1);
    repeat (3) @(negedge clk);
    check("R10 held", {31'h0, cpIrq}, 32'h1);
    cpDbAck = 1'b1; @(negedge clk); cpDbAck = 1'b0;
    check("R10 ack clears", {31'h0, cpIrq}, 32'h0);
    @(negedge clk);
    dbWrEn = 1'b1; dbAddr = 4'h4; dbWrMsb = 1'b1; cpDbAck = 1'b1;
    @(negedge clk);
    dbWrEn = 1'b0; dbWrMsb = 1'b0; cpDbAck = 1'b0;
    check("R10 set beats ack", {31'h0, cpIrq}, 32'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule